// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Sensing

This block is one bank of general-purpose pins behind a 32-bit register port. Software chooses, pin by pin, whether a line is a plain input, a driven output, or an interrupt source. Interrupt sources each carry their own polarity, a choice between level and edge sensing, and a choice between one edge and both edges. All pin-sensed results feed a single combined interrupt line.

Pin inputs cross into the clock domain through a synchroniser. A per-pin input gate can force a line to read as zero and keep it from raising an interrupt. Edge events are latched in a pending register and cleared by writing ones to a clear register. Level events are shown live. Masking uses two registers: one only removes enables (bits written as zero) and one only adds them (bits written as one). The bank width is a parameter, and a second parameter selects whether input data shows the pin level or, for output pins, the output-data bit.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every configuration register, the enable (mask readback) register, the input-gate register and the pending register read 0, `pin_oe` is 0 and `irq` is low.
- R2: `pin_oe[i]` is 1 only when the direction bit (offset 0x04, 1 = output) is 1 and the mode bit (offset 0x00, 1 = interrupt input) is 0; `pin_out` equals the output-data register (offset 0x08).
- R3: Input data (offset 0x0C) shows each pin level two clock edges after it changes. With `READ_PIN_ALWAYS` = 0, a general-mode output pin reads its output-data bit instead.
- R4: With `HAS_INPUT_GATE` = 1, a pin whose gate bit (offset 0x50) is 0 reads 0 in input data and never raises a level or edge interrupt.
- R5: In level mode (edge/level bit at 0x24 = 0) the pending bit (offset 0x10) equals the gated pin level XOR the polarity bit (offset 0x20, 1 = active low) and is not latched; writing the clear register does not change it.
- R6: In edge mode with the both-edge bit (offset 0x4C) at 0, polarity 0 latches a rising edge and polarity 1 a falling edge; the pending bit is set three edges after the pin change and holds until a 1 is written to that bit of the clear register (offset 0x14). Bits written as 0 have no effect.
- R7: With the both-edge bit at 1 an edge-mode pin latches on both transitions and its polarity bit is ignored.
- R8: When a new edge and a clear of the same bit land on the same clock edge, the pending bit ends up set.
- R9: A write to the mask register (offset 0x18) clears the enable of every bit written 0 and keeps the others. A write to the unmask register (offset 0x1C) sets the enable of every bit written 1. Reading 0x18 returns the enables.
- R10: `irq` is high exactly when some pin is both pending and enabled.
- R11: Bits at and above `NUM_LINES` read 0 and ignore writes; the chatter-control offset 0x28 and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high with `bus_sel` |
| bus_addr | input | 7 | Byte offset of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_LINES | Pin levels from the pads, asynchronous |
| pin_out | output | NUM_LINES | Output data to the pads |
| pin_oe | output | NUM_LINES | Output enable to the pads |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the clock edge that accepts it, so readback, `pin_oe`, `pin_out`, level pending and `irq` are checked just after that edge. A pin change needs two edges to reach input data and level pending, and a third to latch an edge into the pending register. The bench drives pins at a falling edge, counts rising edges explicitly and samples shortly after the due edge. For the edge cases it also checks one edge early that nothing has been latched yet. The same-cycle race is built by placing the clear write on exactly the third edge after the pin change.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

  // Register byte offsets; software decodes these, so they stay fixed.
  localparam logic [6:0] OFS_MODE   = 7'h00;
  localparam logic [6:0] OFS_DIR    = 7'h04;
  localparam logic [6:0] OFS_ODATA  = 7'h08;
  localparam logic [6:0] OFS_IDATA  = 7'h0C;
  localparam logic [6:0] OFS_PEND   = 7'h10;
  localparam logic [6:0] OFS_CLR    = 7'h14;
  localparam logic [6:0] OFS_MASK   = 7'h18;
  localparam logic [6:0] OFS_UNMASK = 7'h1C;
  localparam logic [6:0] OFS_POL    = 7'h20;
  localparam logic [6:0] OFS_EDGE   = 7'h24;
  localparam logic [6:0] OFS_BOTH   = 7'h4C;
  localparam logic [6:0] OFS_GATE   = 7'h50;

  // Edge events per bit: both-edge picks any transition, otherwise polarity
  // picks rising (0) or falling (1).
  function automatic logic [31:0] edge_hits(input logic [31:0] cur,
                                            input logic [31:0] prv,
                                            input logic [31:0] pol,
                                            input logic [31:0] both);
    logic [31:0] rise;
    logic [31:0] fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    return (both & (rise | fall)) | (~both & ((~pol & rise) | (pol & fall)));
  endfunction

  // Level activity: level XOR polarity.
  function automatic logic [31:0] level_active(input logic [31:0] cur,
                                               input logic [31:0] pol);
    return cur ^ pol;
  endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s - 1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpb_sense.sv
module gpb_sense
  import gpb_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] gate_ok,
  input  logic [W-1:0] mode_irq,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] both_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] pend,
  output logic [W-1:0] edge_evt
);
  logic [W-1:0] prv;
  logic [W-1:0] pend_edge_r;
  logic [W-1:0] hits;
  logic [W-1:0] lvl;
  logic [W-1:0] edge_pins;
  logic [W-1:0] lvl_pins;

  assign edge_pins = mode_irq & edge_sel;
  assign lvl_pins  = mode_irq & ~edge_sel;
  assign hits = W'(edge_hits(32'(cur), 32'(prv), 32'(pol), 32'(both_sel)));
  assign lvl  = W'(level_active(32'(cur), 32'(pol)));
  assign edge_evt = hits & edge_pins & gate_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv         <= '0;
      pend_edge_r <= '0;
    end else begin
      prv         <= cur;
      // new edge beats a clear in the same cycle
      pend_edge_r <= edge_pins & ((pend_edge_r & ~clr) | edge_evt);
    end
  end

  assign pend = (edge_pins & pend_edge_r) | (lvl_pins & gate_ok & lvl);

  // R6 / R8: an edge event is latched on the next edge, whatever the clear does
  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt != '0) |=> ((pend & $past(edge_evt)) == $past(edge_evt)));

  // R4: a gated-off level pin never shows pending
  a_r4_gate_blocks_level: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & lvl_pins & ~gate_ok) == '0);

  // R6: a clear with no new edge drops a latched edge bit
  a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & edge_pins & ~edge_evt) != '0) |=>
      ((pend_edge_r & $past(clr & edge_pins & ~edge_evt)) == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpb_pkg::*;
#(
  parameter int NUM_LINES       = 32,
  parameter int SYNC_STAGES     = 2,
  parameter bit READ_PIN_ALWAYS = 1'b1,
  parameter bit HAS_INPUT_GATE  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [6:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] pin_in,
  output logic [NUM_LINES-1:0] pin_out,
  output logic [NUM_LINES-1:0] pin_oe,
  output logic                 irq
);
  localparam int N = NUM_LINES;
  localparam logic [31:0] LMASK = (N >= 32) ? 32'hFFFF_FFFF : ((32'd1 << N) - 32'd1);

  logic [N-1:0] mode_r, dir_r, odata_r, pol_r, edge_r, both_r, en_r, gate_r;
  logic [N-1:0] synced, gate_ok, cur, pend, edge_evt, clr, gp_out, idata;
  logic [N-1:0] wd;
  logic         wr;
  logic         wr_mask, wr_unmask;

  assign wr        = bus_sel & bus_we;
  assign wd        = bus_wdata[N-1:0];
  assign wr_mask   = wr && (bus_addr == OFS_MASK);
  assign wr_unmask = wr && (bus_addr == OFS_UNMASK);
  assign clr       = (wr && (bus_addr == OFS_CLR)) ? wd : '0;

  gpb_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(synced)
  );

  if (HAS_INPUT_GATE) begin : g_gate
    assign gate_ok = gate_r;
  end else begin : g_nogate
    assign gate_ok = '1;
  end
  assign cur = synced & gate_ok;

  gpb_sense #(.W(N)) u_sense (
    .clk(clk), .rst_n(rst_n), .cur(cur), .gate_ok(gate_ok),
    .mode_irq(mode_r), .edge_sel(edge_r), .both_sel(both_r), .pol(pol_r),
    .clr(clr), .pend(pend), .edge_evt(edge_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_r <= '0; dir_r <= '0; odata_r <= '0; pol_r <= '0;
      edge_r <= '0; both_r <= '0; en_r <= '0; gate_r <= '0;
    end else if (wr) begin
      case (bus_addr)
        OFS_MODE:   mode_r  <= wd;
        OFS_DIR:    dir_r   <= wd;
        OFS_ODATA:  odata_r <= wd;
        OFS_POL:    pol_r   <= wd;
        OFS_EDGE:   edge_r  <= wd;
        OFS_BOTH:   both_r  <= wd;
        OFS_MASK:   en_r    <= en_r & wd;
        OFS_UNMASK: en_r    <= en_r | wd;
        OFS_GATE:   gate_r  <= HAS_INPUT_GATE ? wd : '0;
        default: ;
      endcase
    end
  end

  assign gp_out  = dir_r & ~mode_r;
  assign pin_oe  = gp_out;
  assign pin_out = odata_r;
  assign idata   = READ_PIN_ALWAYS ? cur : ((cur & ~gp_out) | (odata_r & gp_out));
  assign irq     = |(pend & en_r);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MODE:   bus_rdata = 32'(mode_r);
      OFS_DIR:    bus_rdata = 32'(dir_r);
      OFS_ODATA:  bus_rdata = 32'(odata_r);
      OFS_IDATA:  bus_rdata = 32'(idata);
      OFS_PEND:   bus_rdata = 32'(pend);
      OFS_MASK:   bus_rdata = 32'(en_r);
      OFS_POL:    bus_rdata = 32'(pol_r);
      OFS_EDGE:   bus_rdata = 32'(edge_r);
      OFS_BOTH:   bus_rdata = 32'(both_r);
      OFS_GATE:   bus_rdata = 32'(gate_r);
      default:    bus_rdata = '0;
    endcase
  end

  // R9: after a mask write no bit written as zero stays enabled
  a_r9_mask_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> ((en_r & ~$past(wd)) == '0));

  // R9: after an unmask write every bit written as one is enabled
  a_r9_unmask_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((en_r & $past(wd)) == $past(wd)));

  // R10: the combined line needs at least one enabled and pending pin
  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((en_r != '0) && (pend != '0)));

  // R2: an interrupt-mode pin never drives the pad
  a_r2_no_drive_in_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & mode_r) == '0);

  // R11: nothing appears above the line count
  a_r11_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~LMASK) == 32'd0);
endmodule

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [6:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] pin_in = '0;
  logic [NL-1:0] pin_out;
  logic [NL-1:0] pin_oe;
  logic          irq;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_bank #(.NUM_LINES(NL), .SYNC_STAGES(2), .READ_PIN_ALWAYS(1'b0),
                  .HAS_INPUT_GATE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {offset, write value, expected readback}
  localparam logic [70:0] REG_TABLE [8] = '{
    {7'h04, 32'hFFFF_FFFF, 32'h000F_FFFF},
    {7'h08, 32'hA5A5_A5A5, 32'h0005_A5A5},
    {7'h20, 32'hFFFF_0000, 32'h000F_0000},
    {7'h24, 32'h1234_5678, 32'h0004_5678},
    {7'h4C, 32'hFFFF_FFFF, 32'h000F_FFFF},
    {7'h50, 32'hFFFF_FFFF, 32'h000F_FFFF},
    {7'h00, 32'h0F0F_0F0F, 32'h000F_0F0F},
    {7'h28, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic pins(input logic [NL-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(7'h00, v); chk("R1 mode", v, 0);
    rd(7'h04, v); chk("R1 dir", v, 0);
    rd(7'h18, v); chk("R1 enables", v, 0);
    rd(7'h50, v); chk("R1 gate", v, 0);
    rd(7'h10, v); chk("R1 pending", v, 0);
    chk("R1 pin_oe", 32'(pin_oe), 0);
    chk("R1 irq", 32'(irq), 0);

    // R11 / R12 register table walk
    for (int i = 0; i < 8; i++) begin
      wr(REG_TABLE[i][70:64], REG_TABLE[i][63:32]);
      rd(REG_TABLE[i][70:64], v);
      chk("R11 readback", v, REG_TABLE[i][31:0]);
    end

    // R2 pad controls
    chk("R2 pin_oe", 32'(pin_oe), 32'h0000_F0F0);
    chk("R2 pin_out", 32'(pin_out), 32'h0005_A5A5);

    wr(7'h00, 0); wr(7'h04, 0); wr(7'h08, 0);
    wr(7'h20, 0); wr(7'h24, 0); wr(7'h4C, 0);

    // R3 input readback timing
    pins(20'h12345);
    tick(1);
    rd(7'h0C, v); chk("R3 not yet", v, 0);
    tick(1);
    rd(7'h0C, v); chk("R3 input data", v, 32'h0001_2345);
    wr(7'h04, 32'h1);
    rd(7'h0C, v); chk("R3 output pin reads odata", v, 32'h0001_2344);
    wr(7'h04, 0);

    // R4 gate off pin 0
    wr(7'h50, 32'h000F_FFFE);
    rd(7'h0C, v); chk("R4 gated reads zero", v, 32'h0001_2344);
    wr(7'h00, 32'h1); wr(7'h1C, 32'h1);
    rd(7'h10, v); chk("R4 gated no pending", v, 0);
    chk("R4 irq", 32'(irq), 0);

    // R5 level mode on pin 2 (high)
    wr(7'h00, 32'h5); wr(7'h1C, 32'h4);
    rd(7'h10, v); chk("R5 level pending", v, 32'h4);
    chk("R10 irq level", 32'(irq), 1);
    wr(7'h14, 32'h4);
    rd(7'h10, v); chk("R5 clear ignored", v, 32'h4);
    wr(7'h20, 32'h4);
    rd(7'h10, v); chk("R5 polarity low", v, 0);
    chk("R10 irq off", 32'(irq), 0);
    wr(7'h20, 0);

    // R9 split mask
    wr(7'h18, 32'hFFFF_FFFB);
    rd(7'h18, v); chk("R9 mask clears", v, 32'h1);
    chk("R10 irq masked", 32'(irq), 0);
    wr(7'h18, 32'hFFFF_FFFF);
    rd(7'h18, v); chk("R9 ones keep", v, 32'h1);
    wr(7'h1C, 32'h4);
    rd(7'h18, v); chk("R9 unmask sets", v, 32'h5);
    chk("R10 irq unmasked", 32'(irq), 1);
    wr(7'h18, 0);
    wr(7'h00, 0);

    // R6 rising edge on pin 4
    wr(7'h00, 32'h10); wr(7'h24, 32'h10); wr(7'h1C, 32'h10);
    rd(7'h10, v); chk("R6 idle", v, 0);
    pins(20'h12355);
    tick(2);
    rd(7'h10, v); chk("R6 one edge early", v, 0);
    tick(1);
    rd(7'h10, v); chk("R6 rise latched", v, 32'h10);
    chk("R10 irq edge", 32'(irq), 1);
    pins(20'h12345);
    tick(4);
    rd(7'h10, v); chk("R6 held after fall", v, 32'h10);
    wr(7'h14, 32'h0);
    rd(7'h10, v); chk("R6 zero clear no effect", v, 32'h10);
    wr(7'h14, 32'h10);
    rd(7'h10, v); chk("R6 cleared", v, 0);

    // R6 falling polarity
    wr(7'h20, 32'h10);
    pins(20'h12355);
    tick(3);
    rd(7'h10, v); chk("R6 rise ignored", v, 0);
    pins(20'h12345);
    tick(3);
    rd(7'h10, v); chk("R6 fall latched", v, 32'h10);
    wr(7'h14, 32'h10);

    // R7 both edges, polarity still 1
    wr(7'h4C, 32'h10);
    pins(20'h12355);
    tick(3);
    rd(7'h10, v); chk("R7 rise", v, 32'h10);
    wr(7'h14, 32'h10);
    rd(7'h10, v); chk("R7 cleared", v, 0);
    pins(20'h12345);
    tick(3);
    rd(7'h10, v); chk("R7 fall", v, 32'h10);
    wr(7'h14, 32'h10);

    // R8 clear lands on the edge that latches a new event
    pins(20'h12355);
    @(posedge clk);
    @(posedge clk);
    wr(7'h14, 32'h10);
    rd(7'h10, v); chk("R8 edge wins", v, 32'h10);
    wr(7'h14, 32'h10);
    rd(7'h10, v); chk("R8 later clear", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule